// File: doc/BRIEF.md
# Single-Channel DAC Command Controller

This block sits behind a serial-interface front end that collects 24-bit frames. Each frame arrives as one command byte followed by a 16-bit payload, and is presented with a one-cycle `frame_valid` strobe. The controller decodes the frame against a multichannel-style command set and acts only on channel 0.

It keeps three registers:

- a preload (staging) code;
- an active output code;
- a 3-bit configuration holding the write-block flag and two power-down flags.

Its outputs drive the analog converter: the active code, a power-down flag and a termination select. Three level-sensitive pins also act on the registers. A load pin makes the output follow the preload register. A clear pin forces everything back to defaults. A strap pin chooses whether the default code is zero or mid-scale.

Read commands return a register on `read_data`, one cycle after the frame. The command byte is echoed in the upper eight bits, so the front end can shift the word out on the next transaction.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) sets the preload and output registers to the default code, which is 0x0000 with `mid_strap` low and 0x8000 with it high. The configuration register goes to 3'b100 (write-block on, both power-down flags off). Command 0x01 has the same effect.
- R2: Command byte 00001_aaa with aaa=000 writes the payload to the preload register. In write-through mode it also writes the output register. With aaa not 000 the command changes nothing.
- R3: Command 00010_aaa with aaa=000 writes the payload to both preload and output, whatever the mode. Command 00100_aaa writes both for any aaa.
- R4: Command 0x18 with payload bit 0 set copies preload to output. With payload bit 0 clear it changes nothing.
- R5: Command 0x28 sets the write-block flag (configuration bit 2) to payload bit 0, where 1 means write-block.
- R6: Command 0x30 sets the power-down flags from the payload. Bit 0 set selects 10k termination (configuration bit 1, with `pwr_down` and `term_10k` both high). Bit 8 set with bit 0 clear selects high impedance (configuration bit 0, with `pwr_down` high and `term_10k` low). Both bits clear leaves power-down.
- R7: While `load_n` is low, `dac_code` equals the preload register one clock after any change to it, including block-mode writes.
- R8: While `clear_n` is low, all registers are held at their R1 defaults (using the current `mid_strap`) and commands are ignored.
- R9: Command 0x80 reads the preload register, 0x88 the output register and 0x90 the configuration. `read_valid` pulses for one cycle after the frame, with `read_data` = {command byte, 16-bit value}. For the configuration read, value bits 15..3 are zero. Reads addressed to other channels produce no pulse.
- R10: Every other command byte, including 0x00, leaves all registers unchanged and produces no read pulse.
- R11: Writes and reads work normally while the channel is powered down.
- R12: A frame takes effect at the first rising edge at which `frame_valid` is high. The frame contents are ignored while `frame_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| frame_valid | input | 1 | One-cycle strobe marking a completed frame |
| frame_data | input | 24 | Command byte [23:16], payload [15:0] |
| load_n | input | 1 | Level-sensitive load, active low |
| clear_n | input | 1 | Level-sensitive clear, active low |
| mid_strap | input | 1 | Default code select: 0 = zero, 1 = mid-scale |
| read_valid | output | 1 | Read result strobe |
| read_data | output | 24 | Echoed command byte and register value |
| dac_code | output | 16 | Active output code |
| pwr_down | output | 1 | Channel powered down |
| term_10k | output | 1 | Power-down output uses 10k termination |

## Verification
The bench sweeps all 256 command bytes from a state in which the preload and output registers differ. A decoder that acts on an unassigned code, on another channel's write or on a foreign read shows up as a moved output code or as a stray read pulse. Power-down is driven with both payload bits set, so a design that lets high impedance win reports the wrong termination. Writes made while the load pin is low, and commands sent while the clear pin is held, expose designs that order the pin override before the command or let a command slip past the clear. Both strap levels are checked after reset and after clear, so a fixed default code is caught.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int CMD_W    = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int FRAME_W  = CMD_W + DATA_W;
    localparam int HIZ_BIT  = DATA_W / 2;
    localparam logic [ADDR_W-1:0] OWN_CHAN = '0;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLR, OP_WR, OP_WRUP, OP_WRAL, OP_LOAD,
        OP_MODE, OP_PDN, OP_RD_PRE, OP_RD_OUT, OP_RD_CFG
    } op_e;

    typedef struct packed {
        logic wblock;
        logic pd_10k;
        logic pd_hiz;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{wblock: 1'b1, pd_10k: 1'b0, pd_hiz: 1'b0};

    typedef struct packed {
        op_e               op;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] payload;
    } dec_t;

    function automatic logic [DATA_W-1:0] default_code(input logic mid);
        return mid ? {1'b1, {(DATA_W-1){1'b0}}} : '0;
    endfunction

    function automatic op_e classify(input logic [CMD_W-1:0] c);
        logic [CMD_W-ADDR_W-1:0] grp;
        logic                    mine;
        grp  = c[CMD_W-1:ADDR_W];
        mine = (c[ADDR_W-1:0] == OWN_CHAN);
        if (c == 8'h01)                  return OP_CLR;
        if (c == 8'h18)                  return OP_LOAD;
        if (c == 8'h28)                  return OP_MODE;
        if (c == 8'h30)                  return OP_PDN;
        if (c == 8'h90)                  return OP_RD_CFG;
        if (grp == 5'b00100)             return OP_WRAL;
        if (grp == 5'b00001 && mine)     return OP_WR;
        if (grp == 5'b00010 && mine)     return OP_WRUP;
        if (grp == 5'b10000 && mine)     return OP_RD_PRE;
        if (grp == 5'b10001 && mine)     return OP_RD_OUT;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    output dec_t               dec
);

    always_comb begin
        dec.cmd     = frame_data[FRAME_W-1:DATA_W];
        dec.payload = frame_data[DATA_W-1:0];
        dec.op      = frame_valid ? classify(dec.cmd) : OP_NONE;
    end

    // R2: a write addressed to another channel must decode to nothing
    always_comb begin
        if (frame_valid && frame_data[FRAME_W-1:FRAME_W-5] == 5'b00001
            && frame_data[DATA_W+ADDR_W-1:DATA_W] != OWN_CHAN)
            assert_foreign_wr_R2: assert (dec.op == OP_NONE);
    end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              mid_strap,
    output logic [DATA_W-1:0] pre_q,
    output logic [DATA_W-1:0] out_q,
    output cfg_t              cfg_q
);

    logic [DATA_W-1:0] pre_n, out_n;
    cfg_t              cfg_n;
    logic [DATA_W-1:0] dflt;

    assign dflt = default_code(mid_strap);

    always_comb begin
        pre_n = pre_q;
        out_n = out_q;
        cfg_n = cfg_q;
        case (dec.op)
            OP_CLR: begin
                pre_n = dflt;
                out_n = dflt;
                cfg_n = CFG_DEFAULT;
            end
            OP_WR: begin
                pre_n = dec.payload;
                if (!cfg_q.wblock) out_n = dec.payload;
            end
            OP_WRUP, OP_WRAL: begin
                pre_n = dec.payload;
                out_n = dec.payload;
            end
            OP_LOAD: if (dec.payload[0]) out_n = pre_q;
            OP_MODE: cfg_n.wblock = dec.payload[0];
            OP_PDN: begin
                cfg_n.pd_10k = dec.payload[0];
                cfg_n.pd_hiz = dec.payload[HIZ_BIT] & ~dec.payload[0];
            end
            default: ;
        endcase
        if (!load_n) out_n = pre_n;
    end

    always_ff @(posedge clk) begin
        if (rst || !clear_n) begin
            pre_q <= dflt;
            out_q <= dflt;
            cfg_q <= CFG_DEFAULT;
        end else begin
            pre_q <= pre_n;
            out_q <= out_n;
            cfg_q <= cfg_n;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cfg_q == CFG_DEFAULT && out_q == default_code($past(mid_strap))));

    assert_wrup_both_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_WRUP && clear_n) |=>
        (pre_q == $past(dec.payload) && out_q == $past(dec.payload)));

    assert_pd_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(cfg_q.pd_10k && cfg_q.pd_hiz));

    assert_load_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_n && clear_n) |=> (out_q == pre_q));

    assert_clear_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (out_q == default_code($past(mid_strap)) && pre_q == out_q
                      && cfg_q == CFG_DEFAULT));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_NONE && load_n && clear_n) |=>
        ($stable(pre_q) && $stable(out_q) && $stable(cfg_q)));

endmodule

// File: rtl/dac_readback.sv
module dac_readback
    import dac_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  dec_t               dec,
    input  logic [DATA_W-1:0]  pre_q,
    input  logic [DATA_W-1:0]  out_q,
    input  cfg_t               cfg_q,
    output logic               read_valid,
    output logic [FRAME_W-1:0] read_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            read_valid <= 1'b0;
            read_data  <= '0;
        end else begin
            read_valid <= 1'b0;
            case (dec.op)
                OP_RD_PRE: begin
                    read_valid <= 1'b1;
                    read_data  <= {dec.cmd, pre_q};
                end
                OP_RD_OUT: begin
                    read_valid <= 1'b1;
                    read_data  <= {dec.cmd, out_q};
                end
                OP_RD_CFG: begin
                    read_valid <= 1'b1;
                    read_data  <= {dec.cmd, {(DATA_W-3){1'b0}}, cfg_q};
                end
                default: ;
            endcase
        end
    end

    assert_cfg_read_R9: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_RD_CFG) |=>
        (read_valid && read_data[DATA_W-1:3] == '0
         && read_data[FRAME_W-1:DATA_W] == $past(dec.cmd)));

    assert_read_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        read_valid |=> (!read_valid || $past(dec.op) != OP_NONE));

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic               load_n,
    input  logic               clear_n,
    input  logic               mid_strap,
    output logic               read_valid,
    output logic [FRAME_W-1:0] read_data,
    output logic [DATA_W-1:0]  dac_code,
    output logic               pwr_down,
    output logic               term_10k
);

    dec_t              dec;
    logic [DATA_W-1:0] pre_q, out_q;
    cfg_t              cfg_q;

    dac_cmd_decode u_decode (
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .dec         (dec)
    );

    dac_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .load_n    (load_n),
        .clear_n   (clear_n),
        .mid_strap (mid_strap),
        .pre_q     (pre_q),
        .out_q     (out_q),
        .cfg_q     (cfg_q)
    );

    dac_readback u_read (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .pre_q      (pre_q),
        .out_q      (out_q),
        .cfg_q      (cfg_q),
        .read_valid (read_valid),
        .read_data  (read_data)
    );

    assign dac_code = out_q;
    assign pwr_down = cfg_q.pd_10k | cfg_q.pd_hiz;
    assign term_10k = cfg_q.pd_10k;

    // R12: an unstrobed frame must not move the output
    assert_frame_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (!frame_valid && load_n && clear_n) |=> $stable(dac_code));

endmodule

// File: tb/dac_cmd_ctrl_tb.sv
module dac_cmd_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_valid;
    logic [23:0] frame_data;
    logic        load_n, clear_n, mid_strap;
    logic        read_valid;
    logic [23:0] read_data;
    logic [15:0] dac_code;
    logic        pwr_down, term_10k;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dac_cmd_ctrl u_dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
        .load_n(load_n), .clear_n(clear_n), .mid_strap(mid_strap),
        .read_valid(read_valid), .read_data(read_data), .dac_code(dac_code),
        .pwr_down(pwr_down), .term_10k(term_10k)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // entered at a falling edge; returns at the falling edge after the executing edge
    task automatic send(input logic [7:0] c, input logic [15:0] d);
        frame_valid = 1'b1;
        frame_data  = {c, d};
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] c, input logic [15:0] exp);
        send(c, 16'h0000);
        chk({tag, " read_valid"}, {31'd0, read_valid}, 32'd1);
        chk({tag, " read_data"}, {8'd0, read_data}, {8'd0, c, exp});
    endtask

    function automatic bit acts(input logic [7:0] c);
        return c == 8'h01 || c == 8'h08 || c == 8'h10 || c == 8'h18 ||
               c == 8'h28 || c == 8'h30 || c[7:3] == 5'b00100;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; frame_valid = 1'b0; frame_data = '0;
        load_n = 1'b1; clear_n = 1'b1; mid_strap = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, zero strap
        chk("R1 code zero strap", {16'd0, dac_code}, 32'h0000);
        chk("R1 pwr_down", {31'd0, pwr_down}, 0);
        chk("R1 term_10k", {31'd0, term_10k}, 0);
        chk("R1 read_valid idle", {31'd0, read_valid}, 0);
        rd_chk("R1 cfg default", 8'h90, 16'h0004);

        // R1: reset with mid-scale strap
        mid_strap = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 code mid strap", {16'd0, dac_code}, 32'h8000);
        rd_chk("R1 preload mid", 8'h80, 16'h8000);
        mid_strap = 1'b0;

        // R2: block-mode write touches preload only
        send(8'h08, 16'h1234);
        chk("R2 block out held", {16'd0, dac_code}, 32'h8000);
        rd_chk("R2 preload", 8'h80, 16'h1234);
        rd_chk("R9 out read", 8'h88, 16'h8000);

        // R4: software load
        send(8'h18, 16'h0000);
        chk("R4 bit0 clear", {16'd0, dac_code}, 32'h8000);
        send(8'h18, 16'h0002);
        chk("R4 other channel", {16'd0, dac_code}, 32'h8000);
        send(8'h18, 16'h0001);
        chk("R4 transfer", {16'd0, dac_code}, 32'h1234);

        // R5: write-through, then sweep
        send(8'h28, 16'h0000);
        rd_chk("R5 cfg thru", 8'h90, 16'h0000);
        d = 16'h0000;
        for (int i = 0; i < 40; i++) begin
            d = 16'(i * 16'h0841 + 16'h0105);
            send(8'h08, d);
            chk("R2 write-through", {16'd0, dac_code}, {16'd0, d});
        end
        send(8'h0B, 16'hFFFF);
        chk("R2 foreign chan out", {16'd0, dac_code}, {16'd0, d});
        rd_chk("R2 foreign chan pre", 8'h80, d);
        send(8'h28, 16'h00FF);
        rd_chk("R5 cfg block", 8'h90, 16'h0004);

        // R3: immediate and broadcast writes in block mode
        send(8'h10, 16'hABCD);
        chk("R3 wrup out", {16'd0, dac_code}, 32'hABCD);
        rd_chk("R3 wrup pre", 8'h80, 16'hABCD);
        send(8'h11, 16'h1111);
        chk("R3 wrup other chan", {16'd0, dac_code}, 32'hABCD);
        send(8'h25, 16'h5555);
        chk("R3 wral out", {16'd0, dac_code}, 32'h5555);
        rd_chk("R3 wral pre", 8'h80, 16'h5555);

        // R6: power-down encodings
        send(8'h30, 16'h0100);
        chk("R6 hiz pwr", {31'd0, pwr_down}, 1);
        chk("R6 hiz term", {31'd0, term_10k}, 0);
        rd_chk("R6 hiz cfg", 8'h90, 16'h0005);
        send(8'h30, 16'h0001);
        chk("R6 10k term", {31'd0, term_10k}, 1);
        rd_chk("R6 10k cfg", 8'h90, 16'h0006);
        send(8'h30, 16'h0101);
        chk("R6 both pwr", {31'd0, pwr_down}, 1);
        chk("R6 both term", {31'd0, term_10k}, 1);
        rd_chk("R6 both cfg", 8'h90, 16'h0006);
        send(8'h10, 16'h2222);
        chk("R11 write in pd", {16'd0, dac_code}, 32'h2222);
        rd_chk("R11 read in pd", 8'h88, 16'h2222);
        send(8'h30, 16'h0000);
        chk("R6 exit pwr", {31'd0, pwr_down}, 0);
        rd_chk("R6 exit cfg", 8'h90, 16'h0004);

        // R7: load pin
        send(8'h08, 16'h3333);
        chk("R7 before load", {16'd0, dac_code}, 32'h2222);
        load_n = 1'b0;
        @(negedge clk);
        chk("R7 load transfer", {16'd0, dac_code}, 32'h3333);
        send(8'h08, 16'h4444);
        chk("R7 block write follows", {16'd0, dac_code}, 32'h4444);
        load_n = 1'b1;
        send(8'h08, 16'h5555);
        chk("R7 released", {16'd0, dac_code}, 32'h4444);

        // R12: unstrobed frame ignored
        frame_data = {8'h10, 16'h1357};
        @(negedge clk);
        chk("R12 no strobe", {16'd0, dac_code}, 32'h4444);

        // R8: clear pin with mid strap
        send(8'h28, 16'h0000);
        send(8'h30, 16'h0001);
        mid_strap = 1'b1; clear_n = 1'b0;
        send(8'h10, 16'h7777);
        chk("R8 clear code", {16'd0, dac_code}, 32'h8000);
        chk("R8 clear pwr", {31'd0, pwr_down}, 0);
        clear_n = 1'b1;
        @(negedge clk);
        rd_chk("R8 clear pre", 8'h80, 16'h8000);
        rd_chk("R8 clear cfg", 8'h90, 16'h0004);

        // R1: clear command with zero strap
        mid_strap = 1'b0;
        send(8'h10, 16'h9999);
        send(8'h30, 16'h0100);
        send(8'h01, 16'h0000);
        chk("R1 clr cmd code", {16'd0, dac_code}, 32'h0000);
        chk("R1 clr cmd pwr", {31'd0, pwr_down}, 0);
        rd_chk("R1 clr cmd cfg", 8'h90, 16'h0004);
        rd_chk("R1 clr cmd pre", 8'h80, 16'h0000);

        // R10 / R9: sweep of every command byte
        send(8'h08, 16'h0F0F);
        for (int c = 0; c < 256; c++) begin
            if (!acts(8'(c))) begin
                send(8'(c), 16'hFFFF);
                chk("R10 code held", {16'd0, dac_code}, 32'h0000);
                chk("R10 pwr held", {31'd0, pwr_down}, 0);
                chk("R9 read pulse", {31'd0, read_valid},
                    (c == 8'h80 || c == 8'h88 || c == 8'h90) ? 1 : 0);
            end
        end
        rd_chk("R10 pre held", 8'h80, 16'h0F0F);
        rd_chk("R10 cfg held", 8'h90, 16'h0004);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule